// File: doc/BRIEF.md
# Dual LED Blink Indicator Controller

This block drives two status LEDs, one red and one blue, from a small set of static configuration bits. Each LED shows one of four blink duty cycles, from steadily lit down to one eighth of the blink period. When an LED is set to steadily lit, an optional power-saving mode pulses it at a fast 1-in-4 rate instead. Each LED also has a force-off control. The blue LED can be made to follow a signal-detected flag, so that it is lit only while a valid signal is present.

A free-running prescaler divides the clock into a blink tick. The tick advances an eight-phase counter, and that counter produces the duty patterns. A global half-rate control doubles the tick spacing, which slows both LEDs. The tick also leaves the block as a one-cycle strobe, which the signal-detect logic elsewhere uses as its sampling rate. The block has an asynchronous active-low reset that is released through a two-flop synchronizer. Both LED outputs are registered.

Top module: `led_blink_ctrl`

## Requirements
- R1: The duty code selects the lit phases of the eight-phase blink counter: code 00 lights all phases, 01 lights phases 0 to 3, 10 lights phases 0 and 1, and 11 lights phase 0 only.
- R2: With the modulate bit set and duty code 00, the LED is lit only in the cycles where the two low prescaler bits are 00, which is one cycle in four. The modulate bit has no effect with any other duty code.
- R3: The force-off bit of an LED holds that LED dark whatever its other settings are. It has the highest priority.
- R4: With blue-follow set, the blue LED is dark whenever the detect flag was low at the sampling edge. Otherwise it shows its duty pattern.
- R5: With half-rate clear, the strobe is a one-cycle pulse at the end of every 2^N clock cycles. The blink phase advances by one on each strobe.
- R6: With half-rate set, the strobe and the phase advance come every 2^(N+1) cycles, so the blink period doubles.
- R7: While in reset, both LEDs and the strobe are low. The prescaler and the phase counter start from zero two edges after reset is released, so both LEDs start in phase. Each LED output reflects the counters and the inputs from the edge before.
- R8: The detect flag and the blue-follow bit never affect the red LED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_rate | input | 1 | Doubles the tick spacing |
| red_duty | input | 2 | Red duty code |
| red_mod | input | 1 | Red power-saving modulation |
| red_off | input | 1 | Red force-off |
| blue_duty | input | 2 | Blue duty code |
| blue_mod | input | 1 | Blue power-saving modulation |
| blue_off | input | 1 | Blue force-off |
| blue_follow | input | 1 | Blue LED lit only while the detect flag is high |
| sig_detect | input | 1 | Signal-detected flag |
| red_led | output | 1 | Red LED drive, active high |
| blue_led | output | 1 | Blue LED drive, active high |
| det_strobe | output | 1 | One-cycle detect sampling strobe |

## Verification
The hardest part to reach from the ports is the interaction between the blink phase and the priority chain. A duty pattern, the modulation slot and the detect gating only show up together when the phase counter has reached a specific value while the detect flag has a specific level. The bench sweeps 64 configurations that together cover every red setting at both rates. In each one it releases reset and runs two full blink periods while it toggles the detect flag pseudo-randomly every cycle. Each cycle it compares both LEDs and the strobe with values it computes from the cycle count since release.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;
  typedef enum logic [1:0] {
    DUTY_FULL    = 2'b00,
    DUTY_HALF    = 2'b01,
    DUTY_QUARTER = 2'b10,
    DUTY_EIGHTH  = 2'b11
  } duty_e;

  typedef struct packed {
    duty_e duty;
    logic  modulate;
    logic  force_off;
    logic  follow;
  } led_cfg_t;

  localparam int PHASE_W = 3;
endpackage

// File: rtl/led_rst_sync.sv
module led_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/blink_timebase.sv
module blink_timebase #(
  parameter int N = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                half_rate,
  output logic                                tick,
  output logic                                mod_slot,
  output logic [led_blink_pkg::PHASE_W-1:0]   phase
);
  import led_blink_pkg::*;
  localparam int CNT_W = N + 1;

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [PHASE_W-1:0] phase_q, phase_d;

  always_comb begin
    tick    = half_rate ? (&cnt_q) : (&cnt_q[N-1:0]);
    cnt_d   = cnt_q + CNT_W'(1);
    phase_d = phase_q;
    if (tick) begin
      phase_d = phase_q + PHASE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign mod_slot = (cnt_q[1:0] == 2'b00);
  assign phase    = phase_q;
endmodule

// File: rtl/led_channel.sv
module led_channel (
  input  logic                              clk,
  input  logic                              rst_n,
  input  led_blink_pkg::led_cfg_t           cfg,
  input  logic [led_blink_pkg::PHASE_W-1:0] phase,
  input  logic                              mod_slot,
  input  logic                              detect,
  output logic                              led
);
  import led_blink_pkg::*;

  logic pattern;
  logic led_d;
  logic led_q;

  always_comb begin
    unique case (cfg.duty)
      DUTY_FULL:    pattern = cfg.modulate ? mod_slot : 1'b1;
      DUTY_HALF:    pattern = (phase < PHASE_W'(4));
      DUTY_QUARTER: pattern = (phase < PHASE_W'(2));
      DUTY_EIGHTH:  pattern = (phase == '0);
      default:      pattern = 1'b0;
    endcase
    if (cfg.force_off) begin
      led_d = 1'b0;
    end else if (cfg.follow && !detect) begin
      led_d = 1'b0;
    end else begin
      led_d = pattern;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q <= 1'b0;
    end else begin
      led_q <= led_d;
    end
  end

  assign led = led_q;
endmodule

// File: rtl/led_blink_ctrl.sv
module led_blink_ctrl #(
  parameter int N = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       half_rate,
  input  logic [1:0] red_duty,
  input  logic       red_mod,
  input  logic       red_off,
  input  logic [1:0] blue_duty,
  input  logic       blue_mod,
  input  logic       blue_off,
  input  logic       blue_follow,
  input  logic       sig_detect,
  output logic       red_led,
  output logic       blue_led,
  output logic       det_strobe
);
  import led_blink_pkg::*;
  localparam int NUM_LED = 2;

  logic               rst_int_n;
  logic               tick;
  logic               mod_slot;
  logic [PHASE_W-1:0] phase;
  led_cfg_t           cfg   [NUM_LED];
  logic               leds  [NUM_LED];

  initial begin
    if (N < 2) $error("N must be at least 2 for the modulation slot");
  end

  led_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  blink_timebase #(.N(N)) u_tb (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .half_rate (half_rate),
    .tick      (tick),
    .mod_slot  (mod_slot),
    .phase     (phase)
  );

  // index 0 = red (never follows detect), index 1 = blue
  assign cfg[0] = '{duty: duty_e'(red_duty), modulate: red_mod,
                    force_off: red_off, follow: 1'b0};
  assign cfg[1] = '{duty: duty_e'(blue_duty), modulate: blue_mod,
                    force_off: blue_off, follow: blue_follow};

  for (genvar g = 0; g < NUM_LED; g++) begin : g_led
    led_channel u_ch (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .cfg      (cfg[g]),
      .phase    (phase),
      .mod_slot (mod_slot),
      .detect   (sig_detect),
      .led      (leds[g])
    );
  end

  assign red_led    = leds[0];
  assign blue_led   = leds[1];
  assign det_strobe = tick;
endmodule

// File: rtl/led_blink_ctrl_chk.sv
module led_blink_ctrl_chk (
  input logic       clk,
  input logic       rst_int_n,
  input logic [1:0] red_duty,
  input logic       red_mod,
  input logic       red_off,
  input logic       blue_off,
  input logic       blue_follow,
  input logic       sig_detect,
  input logic       red_led,
  input logic       blue_led,
  input logic       det_strobe
);
  p_full_on_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (red_duty == 2'b00 && !red_mod && !red_off) |=> red_led);

  p_mod_sparse_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (red_led && red_duty == 2'b00 && red_mod && $past(red_duty == 2'b00 && red_mod))
      |=> !red_led);

  p_red_off_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    red_off |=> !red_led);

  p_blue_off_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    blue_off |=> !blue_led);

  p_follow_gate_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (blue_follow && !sig_detect) |=> !blue_led);

  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    det_strobe |=> !det_strobe);
endmodule

bind led_blink_ctrl led_blink_ctrl_chk u_chk (
  .clk         (clk),
  .rst_int_n   (rst_int_n),
  .red_duty    (red_duty),
  .red_mod     (red_mod),
  .red_off     (red_off),
  .blue_off    (blue_off),
  .blue_follow (blue_follow),
  .sig_detect  (sig_detect),
  .red_led     (red_led),
  .blue_led    (blue_led),
  .det_strobe  (det_strobe)
);

// File: tb/tb_led_blink_ctrl.sv
`timescale 1ns/1ps
module tb_led_blink_ctrl;
  localparam int N = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       half_rate = 1'b0;
  logic [1:0] red_duty = 2'b00;
  logic       red_mod = 1'b0;
  logic       red_off = 1'b0;
  logic [1:0] blue_duty = 2'b00;
  logic       blue_mod = 1'b0;
  logic       blue_off = 1'b0;
  logic       blue_follow = 1'b0;
  logic       sig_detect = 1'b0;
  logic       red_led, blue_led, det_strobe;

  int n_checks = 0;
  int n_errors = 0;
  logic [7:0] lfsr = 8'hA5;

  always #5 clk = ~clk;

  led_blink_ctrl #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .half_rate(half_rate),
    .red_duty(red_duty), .red_mod(red_mod), .red_off(red_off),
    .blue_duty(blue_duty), .blue_mod(blue_mod), .blue_off(blue_off),
    .blue_follow(blue_follow), .sig_detect(sig_detect),
    .red_led(red_led), .blue_led(blue_led), .det_strobe(det_strobe)
  );

  task automatic chk(input string tag, input logic act, input logic exp, input int cyc);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  // lit value from the rules: prescaler value and phase before the edge
  function automatic logic exp_led(input logic [1:0] duty, input logic md,
                                   input logic off, input logic fol, input logic det,
                                   input int presc, input int ph);
    if (off) return 1'b0;
    if (fol && !det) return 1'b0;
    case (duty)
      2'b00:   return md ? ((presc % 4) == 0) : 1'b1;
      2'b01:   return ph < 4;
      2'b10:   return ph < 2;
      default: return ph == 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] duty, input logic md,
                                   input logic off, input logic fol, input logic det,
                                   input logic hr);
    if (off) return "R3";
    if (fol && !det) return "R4";
    if (duty == 2'b00 && md) return "R2";
    return hr ? "R6" : "R1";
  endfunction

  task automatic run_cfg(input logic [5:0] i);
    int p;
    int len;
    @(negedge clk);
    rst_n = 1'b0;
    half_rate   = i[5];
    red_duty    = i[1:0];
    red_mod     = i[2];
    red_off     = i[3];
    blue_duty   = i[1:0] ^ {i[4], i[2]};
    blue_mod    = i[4] ^ i[0];
    blue_off    = i[3] & i[4] & i[0];
    blue_follow = i[4];
    @(negedge clk);
    // R7: reset state
    chk("R7", red_led, 1'b0, 0);
    chk("R7", blue_led, 1'b0, 0);
    chk("R7", det_strobe, 1'b0, 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R7", red_led, 1'b0, 0);
    chk("R7", blue_led, 1'b0, 0);
    p   = half_rate ? (1 << (N + 1)) : (1 << N);
    len = 2 * 8 * p + 3;
    for (int k = 1; k <= len; k++) begin
      logic det_used;
      int pre, ph;
      det_used = sig_detect;
      @(posedge clk);
      @(negedge clk);
      pre = (k - 1) % (1 << (N + 1));
      ph  = ((k - 1) / p) % 8;
      // R8: red ignores follow/detect (follow passed as 0 for red)
      chk(tag_of(red_duty, red_mod, red_off, 1'b0, det_used, half_rate),
          red_led, exp_led(red_duty, red_mod, red_off, 1'b0, det_used, pre, ph), k);
      chk(tag_of(blue_duty, blue_mod, blue_off, blue_follow, det_used, half_rate),
          blue_led, exp_led(blue_duty, blue_mod, blue_off, blue_follow, det_used, pre, ph), k);
      chk(half_rate ? "R6" : "R5", det_strobe, ((k % p) == p - 1), k);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      sig_detect = lfsr[0];
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      run_cfg(6'(i));
    end
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule